// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit turns one 6-bit operand specifier into either a register operand or a 16-bit memory effective address. The specifier holds a 3-bit addressing mode in bits [5:3] and a 3-bit register number in bits [2:0]. Eight modes cover direct register, register-indirect, post-increment, pre-decrement, indexed, and the pointer-chasing ("deferred") form of the last three. The same rules apply to every register. Register 7 is the program counter, so immediate, absolute and PC-relative addressing need no special handling. Register 6 is the stack pointer.

The issuing stage pulses `start` with a specifier and a byte/word flag. The unit reads and updates an external 8-entry register file through a combinational read port and a single write port. It fetches index words and pointers through a 16-bit memory read port that is paced by `mem_ready`. When the operand is resolved, `done` pulses for one cycle. `is_reg` then says whether `ea` holds a register number or a memory address. Operand data fetch, writeback and the ALU are handled elsewhere.

Top module: `opnd_ea_unit`

## Requirements
- R1: Mode 0 finishes with `is_reg`=1 and `ea` equal to the register number. It performs no register write and no memory read.
- R2: Mode 1 finishes with `is_reg`=0 and `ea` equal to the register contents. The register file is left unchanged.
- R3: Mode 2 returns the register contents as `ea`, then adds the step to that register.
- R4: Mode 4 subtracts the step from the register and returns the decremented value as `ea`.
- R5: The step of modes 2 and 4 is 2 for word operands (`byte_op`=0). For byte operands it is 1, except for registers 6 and 7, which always step by 2.
- R6: Mode 3 reads a pointer at the register contents and adds 2 to the register. Mode 5 subtracts 2 from the register and reads a pointer at the new value. In both modes, `ea` is the pointer read from memory.
- R7: Modes 6 and 7 read an index word X at the program counter and add 2 to the program counter. Mode 6 returns base+X. Mode 7 reads a pointer at base+X and returns it. The base is the register contents, or PC+2 when the register is 7.
- R8: Every memory read uses an even address, with bit 0 cleared. `mem_addr` holds steady while `mem_req` is high and `mem_ready` is low.
- R9: `done` is high for exactly one cycle per specifier. At most one register write is made per specifier.
- R10: A `start` that arrives while a specifier is being resolved is ignored.
- R11: After reset, `done`, `mem_req` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving `spec` (taken only when idle) |
| spec | input | 6 | Mode [5:3], register number [2:0] |
| byte_op | input | 1 | 1 = byte operand, 0 = word operand |
| done | output | 1 | One-cycle completion pulse |
| is_reg | output | 1 | Operand is a register (valid with `done`) |
| ea | output | 16 | Effective address or register number (valid with `done`) |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 16 | Memory read address (even) |
| mem_ready | input | 1 | Read data valid this cycle |
| mem_rdata | input | 16 | Memory read data |

## Verification
The bench builds the unit with its default parameters: 16-bit addresses, eight registers, the program counter at index 7, the wide-step rule starting at index 6, and even-address forcing enabled. This covers all 64 mode/register pairs in both operand sizes. It reaches the program-counter forms (immediate, absolute, PC-relative and PC-relative deferred) and the byte-step exception for the stack pointer and program counter. Random register contents make odd pointer addresses and wrap-around at 0x0000/0xFFFF occur naturally. Memory latency is randomized to stress the hold rule.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;

   typedef enum logic [2:0] {
      AM_REG    = 3'd0,
      AM_DEF    = 3'd1,
      AM_INC    = 3'd2,
      AM_INCDEF = 3'd3,
      AM_DEC    = 3'd4,
      AM_DECDEF = 3'd5,
      AM_IDX    = 3'd6,
      AM_IDXDEF = 3'd7
   } amode_e;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_DECODE = 3'd1,
      S_PCRD   = 3'd2,
      S_IDXWT  = 3'd3,
      S_PTRWT  = 3'd4
   } ea_state_e;

endpackage

// File: rtl/ea_stepper.sv
`timescale 1ns/1ps
// Chooses the auto-step size from operand size and register index.
module ea_stepper #(
   parameter int ADDR_W     = 16,
   parameter int REG_AW     = 3,
   parameter int WIDE_FIRST = 6
) (
   input  logic              byte_op,
   input  logic [REG_AW-1:0] reg_num,
   output logic [ADDR_W-1:0] step
);
   localparam int REG_CNT = 1 << REG_AW;

   logic [REG_CNT-1:0] wide_mask;

   genvar g;
   generate
      for (g = 0; g < REG_CNT; g++) begin : g_mask
         assign wide_mask[g] = (g >= WIDE_FIRST) ? 1'b1 : 1'b0;
      end
   endgenerate

   assign step = (byte_op && !wide_mask[reg_num]) ? ADDR_W'(1) : ADDR_W'(2);

   initial begin
      AST_WIDE_RANGE: assert (WIDE_FIRST >= 0 && WIDE_FIRST <= REG_CNT)
         else $error("WIDE_FIRST out of range"); // R5
   end
endmodule

// File: rtl/ea_memrd.sv
`timescale 1ns/1ps
// Holds the memory read address for the duration of a request.
module ea_memrd #(
   parameter int ADDR_W     = 16,
   parameter bit FORCE_EVEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              active,
   input  logic              mem_ready,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr
);
   logic [ADDR_W-1:0] addr_n;
   logic [ADDR_W-1:0] addr_q;

   generate
      if (FORCE_EVEN) begin : g_even
         assign addr_n = load_addr & ~ADDR_W'(1);
      end else begin : g_any
         assign addr_n = load_addr;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= addr_n;
   end

   assign mem_req  = active;
   assign mem_addr = addr_q;

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R8

   generate
      if (FORCE_EVEN) begin : g_even_chk
         AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req |-> !mem_addr[0]); // R8
      end
   endgenerate
endmodule

// File: rtl/opnd_ea_unit.sv
`timescale 1ns/1ps
module opnd_ea_unit #(
   parameter int ADDR_W     = 16,
   parameter int REG_AW     = 3,
   parameter int PC_IDX     = 7,
   parameter int WIDE_FIRST = 6,
   parameter bit FORCE_EVEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [5:0]        spec,
   input  logic              byte_op,
   output logic              done,
   output logic              is_reg,
   output logic [15:0]       ea,
   output logic [2:0]        rf_raddr,
   input  logic [15:0]       rf_rdata,
   output logic              rf_we,
   output logic [2:0]        rf_waddr,
   output logic [15:0]       rf_wdata,
   output logic              mem_req,
   output logic [15:0]       mem_addr,
   input  logic              mem_ready,
   input  logic [15:0]       mem_rdata
);
   import ea_pkg::*;

   localparam int                REG_CNT = 1 << REG_AW;
   localparam logic [ADDR_W-1:0] TWO     = ADDR_W'(2);
   localparam logic [REG_AW-1:0] PC_SEL  = REG_AW'(PC_IDX);

   initial begin
      AST_PARAM_W: assert (ADDR_W == 16 && REG_AW == 3)
         else $error("port widths fixed at 16-bit address, 3-bit register index"); // R1
      AST_PARAM_PC: assert (PC_IDX >= 0 && PC_IDX < REG_CNT)
         else $error("PC_IDX out of range"); // R7
   end

   ea_state_e         state_q, state_d;
   amode_e            mode_q;
   logic [REG_AW-1:0] rn_q;
   logic              byte_q;
   logic [ADDR_W-1:0] base_q, base_d;
   logic              done_q, done_d;
   logic              isreg_q, isreg_d;
   logic [ADDR_W-1:0] ea_q, ea_d;
   logic              ld;
   logic [ADDR_W-1:0] ld_addr;
   logic              mem_act;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] idx_sum;
   logic [1:0]        wr_cnt;

   ea_stepper #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .WIDE_FIRST(WIDE_FIRST)) u_step (
      .byte_op (byte_q),
      .reg_num (rn_q),
      .step    (step)
   );

   ea_memrd #(.ADDR_W(ADDR_W), .FORCE_EVEN(FORCE_EVEN)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld),
      .load_addr (ld_addr),
      .active    (mem_act),
      .mem_ready (mem_ready),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr)
   );

   assign rf_raddr = (state_q == S_PCRD) ? PC_SEL : rn_q;
   assign idx_sum  = base_q + mem_rdata;

   always_comb begin
      state_d  = state_q;
      rf_we    = 1'b0;
      rf_waddr = rn_q;
      rf_wdata = rf_rdata;
      done_d   = 1'b0;
      isreg_d  = 1'b0;
      ea_d     = ea_q;
      ld       = 1'b0;
      ld_addr  = rf_rdata;
      base_d   = base_q;
      mem_act  = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (start) state_d = S_DECODE;
         end
         S_DECODE: begin
            unique case (mode_q)
               AM_REG: begin
                  done_d  = 1'b1;
                  isreg_d = 1'b1;
                  ea_d    = {{(ADDR_W-REG_AW){1'b0}}, rn_q};
                  state_d = S_IDLE;
               end
               AM_DEF: begin
                  done_d  = 1'b1;
                  ea_d    = rf_rdata;
                  state_d = S_IDLE;
               end
               AM_INC: begin
                  rf_we    = 1'b1;
                  rf_wdata = rf_rdata + step;
                  done_d   = 1'b1;
                  ea_d     = rf_rdata;
                  state_d  = S_IDLE;
               end
               AM_INCDEF: begin
                  rf_we    = 1'b1;
                  rf_wdata = rf_rdata + TWO;
                  ld       = 1'b1;
                  ld_addr  = rf_rdata;
                  state_d  = S_PTRWT;
               end
               AM_DEC: begin
                  rf_we    = 1'b1;
                  rf_wdata = rf_rdata - step;
                  done_d   = 1'b1;
                  ea_d     = rf_rdata - step;
                  state_d  = S_IDLE;
               end
               AM_DECDEF: begin
                  rf_we    = 1'b1;
                  rf_wdata = rf_rdata - TWO;
                  ld       = 1'b1;
                  ld_addr  = rf_rdata - TWO;
                  state_d  = S_PTRWT;
               end
               default: begin
                  base_d  = rf_rdata;
                  state_d = S_PCRD;
               end
            endcase
         end
         S_PCRD: begin
            rf_we    = 1'b1;
            rf_waddr = PC_SEL;
            rf_wdata = rf_rdata + TWO;
            ld       = 1'b1;
            ld_addr  = rf_rdata;
            if (rn_q == PC_SEL) base_d = rf_rdata + TWO;
            state_d  = S_IDXWT;
         end
         S_IDXWT: begin
            mem_act = 1'b1;
            if (mem_ready) begin
               if (mode_q == AM_IDX) begin
                  done_d  = 1'b1;
                  ea_d    = idx_sum;
                  state_d = S_IDLE;
               end else begin
                  ld      = 1'b1;
                  ld_addr = idx_sum;
                  state_d = S_PTRWT;
               end
            end
         end
         S_PTRWT: begin
            mem_act = 1'b1;
            if (mem_ready) begin
               done_d  = 1'b1;
               ea_d    = mem_rdata;
               state_d = S_IDLE;
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         mode_q  <= AM_REG;
         rn_q    <= '0;
         byte_q  <= 1'b0;
         base_q  <= '0;
         done_q  <= 1'b0;
         isreg_q <= 1'b0;
         ea_q    <= '0;
      end else begin
         state_q <= state_d;
         base_q  <= base_d;
         done_q  <= done_d;
         isreg_q <= isreg_d;
         ea_q    <= ea_d;
         if (state_q == S_IDLE && start) begin
            mode_q <= amode_e'(spec[5:3]);
            rn_q   <= spec[2:0];
            byte_q <= byte_op;
         end
      end
   end

   // Writes made since the current specifier was accepted (checker support).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                wr_cnt <= '0;
      else if (state_q == S_IDLE && start)       wr_cnt <= '0;
      else if (rf_we && wr_cnt != 2'd3)          wr_cnt <= wr_cnt + 2'd1;
   end

   assign done   = done_q;
   assign is_reg = isreg_q;
   assign ea     = ea_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> wr_cnt == 2'd0); // R9
   AST_REG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      done && is_reg |-> wr_cnt == 2'd0 && !mem_req); // R1
   AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we && rf_waddr >= REG_AW'(WIDE_FIRST) |->
         (rf_wdata == rf_rdata + TWO) || (rf_wdata == rf_rdata - TWO)); // R5
   AST_NO_REQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> state_q == S_IDLE); // R10
endmodule

// File: tb/opnd_ea_unit_tb.sv
`timescale 1ns/1ps
module opnd_ea_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [5:0]  spec;
   logic        byte_op;
   logic        done, is_reg;
   logic [15:0] ea;
   logic [2:0]  rf_raddr, rf_waddr;
   logic [15:0] rf_rdata, rf_wdata;
   logic        rf_we;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_ready;
   logic [15:0] mem_rdata;

   always #5 clk = ~clk;

   opnd_ea_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .byte_op(byte_op),
      .done(done), .is_reg(is_reg), .ea(ea),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata)
   );

   // Register file model with a bench load path.
   logic [15:0] regs [8];
   int unsigned wr_total = 0;
   logic        ld_en;
   logic [2:0]  ld_idx;
   logic [15:0] ld_val;

   always @(posedge clk) begin
      if (rf_we) begin
         regs[rf_waddr] <= rf_wdata;
         wr_total       <= wr_total + 1;
      end else if (ld_en) begin
         regs[ld_idx] <= ld_val;
      end
   end
   assign rf_rdata = regs[rf_raddr];

   function automatic logic [15:0] memw(input logic [15:0] a);
      return {a[6:0], a[15:7]} ^ 16'hA5C3 ^ {a[7:0], a[15:8]};
   endfunction
   assign mem_rdata = memw(mem_addr);

   always @(negedge clk) mem_ready <= (($urandom % 3) == 0);

   int n_chk  = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string req_of(input logic [2:0] m);
      case (m)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3/R5";
         3'd4: return "R4/R5";
         3'd3, 3'd5: return "R6";
         default: return "R7";
      endcase
   endfunction

   logic [15:0] init_regs [8];
   logic [15:0] exp_regs [8];
   logic [15:0] exp_ea;
   logic        exp_isreg;
   int          exp_wr;

   task automatic reference(input logic [5:0] sp, input logic bo);
      logic [2:0]  m, r;
      logic [15:0] v, stp, pc, x, base;
      m = sp[5:3];
      r = sp[2:0];
      for (int i = 0; i < 8; i++) exp_regs[i] = init_regs[i];
      v = init_regs[r];
      stp = (bo && r < 3'd6) ? 16'd1 : 16'd2;
      exp_isreg = 1'b0;
      exp_wr = 1;
      case (m)
         3'd0: begin exp_isreg = 1'b1; exp_ea = {13'd0, r}; exp_wr = 0; end
         3'd1: begin exp_ea = v; exp_wr = 0; end
         3'd2: begin exp_ea = v; exp_regs[r] = v + stp; end
         3'd3: begin exp_ea = memw(v & 16'hFFFE); exp_regs[r] = v + 16'd2; end
         3'd4: begin exp_ea = v - stp; exp_regs[r] = v - stp; end
         3'd5: begin exp_ea = memw((v - 16'd2) & 16'hFFFE); exp_regs[r] = v - 16'd2; end
         default: begin
            pc = init_regs[7];
            x = memw(pc & 16'hFFFE);
            exp_regs[7] = pc + 16'd2;
            base = (r == 3'd7) ? pc + 16'd2 : v;
            exp_ea = (m == 3'd6) ? base + x : memw((base + x) & 16'hFFFE);
         end
      endcase
   endtask

   task automatic load_regs();
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_idx = 3'(i); ld_val = init_regs[i];
      end
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic apply(input logic [5:0] sp, input logic bo, input bit restart);
      int          n;
      int unsigned w0;
      string       rq;
      bit          regs_ok;
      rq = req_of(sp[5:3]);
      load_regs();
      reference(sp, bo);
      w0 = wr_total;
      spec = sp; byte_op = bo; start = 1'b1;
      @(negedge clk);
      if (restart) begin spec = ~sp; byte_op = ~bo; end
      else start = 1'b0;
      n = 0;
      while (!done && n < 300) begin
         @(negedge clk);
         start = 1'b0;
         n++;
      end
      check(done == 1'b1, {rq, " done timeout"}, {15'd0, done}, 16'd1);
      check(is_reg == exp_isreg, {rq, " is_reg"}, {15'd0, is_reg}, {15'd0, exp_isreg});
      check(ea == exp_ea, {rq, " ea"}, ea, exp_ea);
      @(negedge clk);
      check(done == 1'b0, "R9 done pulse width", {15'd0, done}, 16'd0);
      check(int'(wr_total - w0) == exp_wr, "R9 write count",
            16'(wr_total - w0), 16'(exp_wr));
      regs_ok = 1'b1;
      for (int i = 0; i < 8; i++) if (regs[i] !== exp_regs[i]) begin
         regs_ok = 1'b0;
         check(1'b0, {rq, " register file"}, regs[i], exp_regs[i]);
      end
      if (regs_ok) check(1'b1, rq, 16'd0, 16'd0);
      if (restart) begin
         n = 0;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done) n++;
         end
         check(n == 0 && wr_total == w0 + 32'(exp_wr), "R10 late start ignored",
               16'(n), 16'd0);
      end
   endtask

   task automatic rand_regs();
      for (int i = 0; i < 8; i++) init_regs[i] = 16'($urandom);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1717));
      rst_n = 1'b0; start = 1'b0; spec = '0; byte_op = 1'b0;
      ld_en = 1'b0; ld_idx = '0; ld_val = '0;
      for (int i = 0; i < 8; i++) regs[i] = 16'h0;
      repeat (3) @(negedge clk);
      check(done == 1'b0 && mem_req == 1'b0 && rf_we == 1'b0, "R11 reset outputs",
            {13'd0, done, mem_req, rf_we}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && mem_req == 1'b0 && rf_we == 1'b0, "R11 idle after reset",
            {13'd0, done, mem_req, rf_we}, 16'd0);

      // Full sweep of all 64 specifiers in both operand sizes.
      for (int s = 0; s < 64; s++) begin
         for (int b = 0; b < 2; b++) begin
            rand_regs();
            apply(6'(s), 1'(b), 1'b0);
         end
      end

      // Directed corners: odd pointers (R8), wrap-around, byte step on SP/PC (R5).
      for (int i = 0; i < 8; i++) init_regs[i] = 16'h1001 + 16'(i * 2);
      apply(6'o32, 1'b0, 1'b0);
      apply(6'o53, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) init_regs[i] = 16'h0000;
      apply(6'o41, 1'b1, 1'b0);
      apply(6'o46, 1'b1, 1'b0);
      apply(6'o47, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) init_regs[i] = 16'hFFFF;
      apply(6'o26, 1'b1, 1'b0);
      apply(6'o27, 1'b1, 1'b0);
      apply(6'o22, 1'b1, 1'b0);
      apply(6'o67, 1'b0, 1'b0);
      apply(6'o77, 1'b0, 1'b0);

      // Restart while busy (R10).
      for (int s = 0; s < 8; s++) begin
         rand_regs();
         apply(6'(s * 8 + 3), 1'b0, 1'b1);
      end

      // Constrained random specifiers.
      for (int k = 0; k < 120; k++) begin
         rand_regs();
         apply(6'($urandom), 1'($urandom), 1'b0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule